// File: doc/BRIEF.md
# Warning-Limited Valve Regulation Controller

This block is a small event-driven controller placed between a driver running in software and an analog tank subsystem made of a valve and a level evaluator. Every input and every output is a one-cycle event pulse.

A driver request arms the controller and sends a start pulse that re-initialises the analog side. While armed, each high-level warning turns into a close command and each low-level warning turns into an open command. Every warning also counts toward a programmable fault limit. When the count goes past that limit, the controller closes the valve, reports an error to the driver, and disarms itself. It then waits for a fresh request.

Two settings are held in the block: the fault limit and a maximum valve aperture. The aperture value is passed straight through to the valve. Both settings are loaded through a write-enable port, and that port is only honoured while the controller is disarmed.

Top module: `lvlctl_top`

## Requirements
- R1: Reset is synchronous and active high. Out of reset the controller is disarmed, all event outputs are low, the fault limit is `DEF_LIMIT` and `max_apt_o` shows `DEF_APT`.
- R2: A request (`arm_i`) while disarmed arms the controller and clears the warning count. `start_o` pulses in the cycle after the request. A request while already armed has no effect.
- R3: While armed, a high warning that does not trip the limit gives a `close_o` pulse in the next cycle.
- R4: While armed, a low warning that does not trip the limit gives an `open_o` pulse in the next cycle.
- R5: If high and low warnings arrive in the same cycle, the high warning wins: only `close_o` pulses, and the count rises by exactly one.
- R6: When a warning makes the count strictly greater than the limit, `error_o` and `close_o` pulse together in the next cycle, `open_o` stays low, and the controller disarms. With a limit of L, warnings 1 to L regulate normally and warning L+1 trips.
- R7: The warning count saturates at 2^CNT_W-1 and does not wrap. With the limit at that maximum, no number of warnings raises an error.
- R8: Warnings received while disarmed produce no output and leave the count unchanged.
- R9: When `cfg_we_i` is high while disarmed, the limit is loaded from `cfg_limit_i` and the aperture from `cfg_apt_i`, visible on `max_apt_o` one cycle later. Writes while armed are ignored.
- R10: Every event output is registered and lasts exactly one cycle per triggering input cycle. `open_o` and `close_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Activation request pulse from the driver |
| warn_hi_i | input | 1 | Level-too-high warning pulse |
| warn_lo_i | input | 1 | Level-too-low warning pulse |
| cfg_we_i | input | 1 | Write enable for both settings |
| cfg_limit_i | input | CNT_W | New fault limit |
| cfg_apt_i | input | APT_W | New maximum aperture |
| start_o | output | 1 | Pulse that re-initialises the analog side |
| open_o | output | 1 | Valve open command pulse |
| close_o | output | 1 | Valve close command pulse |
| error_o | output | 1 | Fault event to the driver |
| max_apt_o | output | APT_W | Current maximum aperture setting |

## Verification
The bench targets the boundaries of the fault limit:
- A limit of zero must trip on the first warning. A design with an off-by-one compare would let one extra warning through, or trip one warning early.
- Simultaneous high and low warnings must give only a close command. A design that double-counted them, or let the low warning win, would open the valve or trip early.
- Warnings and configuration writes sent while disarmed must have no effect. A leaky design would emit commands, shift the later trip point, or change `max_apt_o` while regulating.
- A long run of warnings with the maximum limit must never error. This exposes a counter that wraps instead of saturating.

Long random runs mix all of these, so that each re-arm must also clear the count.

// File: rtl/lvlctl_pkg.sv
package lvlctl_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic start;
        logic open;
        logic close;
        logic error;
    } evt_t;

    localparam evt_t EVT_NONE = '{start: 1'b0, open: 1'b0, close: 1'b0, error: 1'b0};

endpackage

// File: rtl/lvlctl_cfg.sv
module lvlctl_cfg #(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned APT_W     = 8,
    parameter int unsigned DEF_LIMIT = 3,
    parameter int unsigned DEF_APT   = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             locked_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [APT_W-1:0] apt_i,
    output logic [CNT_W-1:0] limit_o,
    output logic [APT_W-1:0] apt_o
);
    localparam logic [CNT_W-1:0] LIMIT_RST = CNT_W'(DEF_LIMIT);
    localparam logic [APT_W-1:0] APT_RST   = APT_W'(DEF_APT);

    logic accept;
    assign accept = we_i && !locked_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_o <= LIMIT_RST;
            apt_o   <= APT_RST;
        end else if (accept) begin
            limit_o <= limit_i;
            apt_o   <= apt_i;
        end
    end

    // R9: settings frozen while armed
    a_r9_apt_frozen: assert property (@(posedge clk) disable iff (rst)
        locked_i |=> $stable(apt_o));
    a_r9_limit_frozen: assert property (@(posedge clk) disable iff (rst)
        locked_i |=> $stable(limit_o));

endmodule

// File: rtl/lvlctl_cnt.sv
module lvlctl_cnt #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] next_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // value the count takes if the current warning is accepted
    assign next_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= next_o;
        end
    end

    // R7: saturation, never wraps back
    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
    // R8: count holds without a warning
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !inc_i) |=> $stable(cnt_q));
    // R2: clear on arm
    a_r2_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0);

endmodule

// File: rtl/lvlctl_fsm.sv
module lvlctl_fsm
    import lvlctl_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             warn_hi_i,
    input  logic             warn_lo_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    output logic             running_o,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output evt_t             evt_o
);
    ctl_state_e state_q, state_d;
    evt_t       evt_d;
    logic       any_warn;
    logic       trip;

    assign any_warn  = warn_hi_i || warn_lo_i;
    assign trip      = cnt_next_i > limit_i;
    assign running_o = (state_q == ST_RUN);

    always_comb begin
        state_d   = state_q;
        evt_d     = EVT_NONE;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_i) begin
                    state_d    = ST_RUN;
                    evt_d.start = 1'b1;
                    cnt_clr_o  = 1'b1;
                end
            end
            ST_RUN: begin
                if (any_warn) begin
                    cnt_inc_o = 1'b1;
                    if (trip) begin
                        evt_d.error = 1'b1;
                        evt_d.close = 1'b1;
                        state_d     = ST_IDLE;
                    end else if (warn_hi_i) begin
                        evt_d.close = 1'b1;
                    end else begin
                        evt_d.open = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            evt_o   <= EVT_NONE;
        end else begin
            state_q <= state_d;
            evt_o   <= evt_d;
        end
    end

    // R2: arm while idle gives start next cycle
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && arm_i) |=> (evt_o.start && state_q == ST_RUN));
    // R6: error always accompanied by close, then idle
    a_r6_err_close: assert property (@(posedge clk) disable iff (rst)
        evt_o.error |-> (evt_o.close && !evt_o.open && state_q == ST_IDLE));
    // R10: open and close exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_o.open, evt_o.close}));
    // R8: warnings while idle give no valve command
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !(evt_o.open || evt_o.close || evt_o.error));
    // R5: high wins over low
    a_r5_hi_wins: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && warn_hi_i && warn_lo_i) |=> (evt_o.close && !evt_o.open));

endmodule

// File: rtl/lvlctl_top.sv
module lvlctl_top
    import lvlctl_pkg::*;
#(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned APT_W     = 8,
    parameter int unsigned DEF_LIMIT = 3,
    parameter int unsigned DEF_APT   = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             warn_hi_i,
    input  logic             warn_lo_i,
    input  logic             cfg_we_i,
    input  logic [CNT_W-1:0] cfg_limit_i,
    input  logic [APT_W-1:0] cfg_apt_i,
    output logic             start_o,
    output logic             open_o,
    output logic             close_o,
    output logic             error_o,
    output logic [APT_W-1:0] max_apt_o
);
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] cnt_next;
    logic             running;
    logic             cnt_clr;
    logic             cnt_inc;
    evt_t             evt;

    lvlctl_cfg #(
        .CNT_W(CNT_W), .APT_W(APT_W), .DEF_LIMIT(DEF_LIMIT), .DEF_APT(DEF_APT)
    ) cfg_i (
        .clk(clk), .rst(rst), .locked_i(running), .we_i(cfg_we_i),
        .limit_i(cfg_limit_i), .apt_i(cfg_apt_i),
        .limit_o(limit_q), .apt_o(max_apt_o)
    );

    lvlctl_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .clr_i(cnt_clr), .inc_i(cnt_inc), .next_o(cnt_next)
    );

    lvlctl_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst(rst), .arm_i(arm_i), .warn_hi_i(warn_hi_i),
        .warn_lo_i(warn_lo_i), .limit_i(limit_q), .cnt_next_i(cnt_next),
        .running_o(running), .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc), .evt_o(evt)
    );

    assign start_o = evt.start;
    assign open_o  = evt.open;
    assign close_o = evt.close;
    assign error_o = evt.error;

endmodule

// File: tb/lvlctl_top_tb_top.sv
module lvlctl_top_tb_top;
    localparam int unsigned CNT_W     = 4;
    localparam int unsigned APT_W     = 8;
    localparam int unsigned DEF_LIMIT = 3;
    localparam int unsigned DEF_APT   = 200;
    localparam int unsigned CMAX      = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm_i = 0, warn_hi_i = 0, warn_lo_i = 0, cfg_we_i = 0;
    logic [CNT_W-1:0] cfg_limit_i = '0;
    logic [APT_W-1:0] cfg_apt_i = '0;
    logic start_o, open_o, close_o, error_o;
    logic [APT_W-1:0] max_apt_o;

    int errors = 0;
    int checks = 0;

    // reference model state
    bit          m_on;
    int unsigned m_cnt, m_lim, m_apt;

    always #5 clk = ~clk;

    lvlctl_top #(.CNT_W(CNT_W), .APT_W(APT_W), .DEF_LIMIT(DEF_LIMIT), .DEF_APT(DEF_APT)) dut_i (
        .clk(clk), .rst(rst), .arm_i(arm_i), .warn_hi_i(warn_hi_i), .warn_lo_i(warn_lo_i),
        .cfg_we_i(cfg_we_i), .cfg_limit_i(cfg_limit_i), .cfg_apt_i(cfg_apt_i),
        .start_o(start_o), .open_o(open_o), .close_o(close_o), .error_o(error_o),
        .max_apt_o(max_apt_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, model update, and comparison of all outputs
    task automatic step(input bit a, input bit h, input bit l, input bit we,
                        input int unsigned lim, input int unsigned apt, input string tag);
        bit es = 0, eo = 0, ec = 0, ee = 0;
        int unsigned n;
        @(negedge clk);
        arm_i = a; warn_hi_i = h; warn_lo_i = l; cfg_we_i = we;
        cfg_limit_i = CNT_W'(lim); cfg_apt_i = APT_W'(apt);
        if (!m_on) begin
            if (we) begin m_lim = lim; m_apt = apt; end
            if (a) begin es = 1; m_on = 1; m_cnt = 0; end
        end else if (h || l) begin
            n = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
            m_cnt = n;
            if (n > m_lim) begin ee = 1; ec = 1; m_on = 0; end
            else if (h) ec = 1;
            else eo = 1;
        end
        @(posedge clk); #1;
        check({tag, " start"}, 32'(start_o), 32'(es));
        check({tag, " open"},  32'(open_o),  32'(eo));
        check({tag, " close"}, 32'(close_o), 32'(ec));
        check({tag, " error"}, 32'(error_o), 32'(ee));
        check({tag, " apt"},   32'(max_apt_o), 32'(m_apt));
    endtask

    initial begin : watchdog
        #1500000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int unsigned seed_dummy;
        m_on = 0; m_cnt = 0; m_lim = DEF_LIMIT; m_apt = DEF_APT;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        // R1: reset state
        check("R1 start", 32'(start_o), 0);
        check("R1 events", 32'({open_o, close_o, error_o}), 0);
        check("R1 apt", 32'(max_apt_o), DEF_APT);

        // R8: warnings while disarmed are ignored
        step(0, 1, 0, 0, 0, 0, "R8 hi idle");
        step(0, 0, 1, 0, 0, 0, "R8 lo idle");
        // R2 with default limit 3: three warnings pass, fourth trips (R6)
        step(1, 0, 0, 0, 0, 0, "R2 arm");
        step(1, 0, 0, 0, 0, 0, "R2 rearm ignored");
        step(0, 1, 0, 0, 0, 0, "R3 close");
        step(0, 0, 1, 0, 0, 0, "R4 open");
        step(0, 1, 1, 0, 0, 0, "R5 both");
        step(0, 0, 1, 0, 0, 0, "R6 trip default");
        step(0, 0, 1, 0, 0, 0, "R8 after trip");

        // R9: write while idle, then try while armed
        step(0, 0, 0, 1, 0, 17, "R9 write idle");
        step(1, 0, 0, 0, 0, 0, "R2 arm lim0");
        step(0, 0, 0, 1, 9, 99, "R9 write armed");
        step(0, 0, 1, 0, 0, 0, "R6 limit zero trips first");

        // R7: maximum limit never errors
        step(0, 0, 0, 1, CMAX, 55, "R9 write max");
        step(1, 0, 0, 0, 0, 0, "R2 arm max");
        for (int i = 0; i < 2 * CMAX + 4; i++) step(0, i % 2, 1, 0, 0, 0, "R7 saturate");

        // R2: re-arm clears the count
        step(0, 0, 0, 0, 0, 0, "R10 idle gap");
        rst = 1; m_on = 0; m_cnt = 0; m_lim = DEF_LIMIT; m_apt = DEF_APT;
        @(posedge clk); #1; rst = 0;
        step(0, 0, 0, 1, 1, 7, "R9 write lim1");
        step(1, 0, 0, 0, 0, 0, "R2 arm a");
        step(0, 1, 0, 0, 0, 0, "R3 one");
        step(0, 1, 0, 0, 0, 0, "R6 trip lim1");
        step(1, 0, 0, 0, 0, 0, "R2 arm b");
        step(0, 0, 1, 0, 0, 0, "R2 count cleared");

        // random mix, fixed seed
        seed_dummy = $urandom(32'h5eed_1234);
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 12) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
                 ($urandom % 8) == 0, $urandom % 5, $urandom % 256, "R10 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule